// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of a five-stage in-order integer pipeline, where the operand value comes from: the register file, the result waiting in the execute/memory pipeline register, or the older result in the memory/writeback pipeline register. It compares the two source register numbers of the instruction now in execute against the destination numbers of the two instructions ahead of it. It only forwards from a producer that will really write a register.

The block is purely combinational and holds no state. The datapath feeds it register numbers and write enables taken from its pipeline registers. The two select codes it returns drive the operand multiplexers in front of the ALU in the same cycle. When both older instructions write the register being read, the younger one wins. A write aimed at register 0 is never forwarded, because that register always reads as zero.

Top module: `fwd_unit`

## Requirements
- R1: Each select is a 2-bit code with these meanings: 2'b00 takes the register-file value, 2'b10 takes the execute/memory result, and 2'b01 takes the memory/writeback result.
- R2: A select is 2'b10 when the execute/memory write enable is 1, that destination is not 0, and that destination equals the operand's source register number.
- R3: A select is 2'b01 when the memory/writeback write enable is 1, that destination is not 0, it equals the operand's source number, and the R2 condition is false for that operand.
- R4: When both producers match the same source, the execute/memory path (2'b10) has priority.
- R5: Operand A (sel_a) is compared only with rs_ex and operand B (sel_b) only with rt_ex. Each is decided independently of the other.
- R6: A producer whose destination is register 0 is never forwarded. A source of 0, with both stages writing register 0, gives 2'b00 on both selects.
- R7: The code 2'b11 never appears on either select.
- R8: A producer with its write enable at 0 is never forwarded, whatever its destination.
- R9: The selects depend only on the present inputs and settle without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_ex | input | 5 | First source register number of the instruction in execute |
| rt_ex | input | 5 | Second source register number of the instruction in execute |
| exmem_rd | input | 5 | Destination register number in the execute/memory register |
| exmem_we | input | 1 | Register-write enable in the execute/memory register |
| memwb_rd | input | 5 | Destination register number in the memory/writeback register |
| memwb_we | input | 1 | Register-write enable in the memory/writeback register |
| sel_a | output | 2 | Source select for ALU operand A |
| sel_b | output | 2 | Source select for ALU operand B |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the inputs and the selects. The bench drives a new input set on the falling clock edge, waits one nanosecond for the logic to settle, and samples both selects well before the next rising edge. It never waits for a clock to see a result. Directed scenarios cover each hazard kind, the register-0 corner and disabled writes. An exhaustive sweep over a reduced register range then compares both selects against a reference written from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Operand source selects; the two-bit codes are decoded by the ALU input muxes
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_EXMEM   = 2'b10
  } fwd_src_e;

  // One producer of a register result further down the pipeline
  typedef struct packed {
    logic       we;
    logic [4:0] rd;
  } producer_t;
endpackage

// File: rtl/fwd_match.sv
// Decides whether one producer can feed one source operand.
module fwd_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             we,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dst_live;
  logic same_reg;

  always_comb begin
    dst_live = we && (dst != ZERO_REG);
    same_reg = (dst == src);
    hit      = dst_live && same_reg;
  end

  // R8
  always_comb begin
    if (!we) begin
      no_disabled_hit_chk: assert (!hit)
        else $error("hit raised with write enable low");
    end
  end
endmodule

// File: rtl/fwd_operand_sel.sv
// Priority choice for one operand: the younger producer wins.
module fwd_operand_sel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic [REG_W-1:0] memwb_rd,
  input  logic             memwb_we,
  output logic [1:0]       sel
);
  import fwd_pkg::*;

  logic young_hit;
  logic old_hit;

  fwd_match #(.REG_W(REG_W)) young_m (
    .src (src),
    .dst (exmem_rd),
    .we  (exmem_we),
    .hit (young_hit)
  );

  fwd_match #(.REG_W(REG_W)) old_m (
    .src (src),
    .dst (memwb_rd),
    .we  (memwb_we),
    .hit (old_hit)
  );

  always_comb begin
    if (young_hit)    sel = SRC_EXMEM;
    else if (old_hit) sel = SRC_WB;
    else              sel = SRC_REGFILE;
  end

  always_comb begin
    // R4
    if (young_hit) begin
      young_wins_chk: assert (sel == SRC_EXMEM)
        else $error("younger producer did not take priority");
    end
    // R6
    if (src == '0) begin
      zero_reg_chk: assert (sel == SRC_REGFILE)
        else $error("register 0 forwarded");
    end
    // R2
    if (sel == SRC_EXMEM) begin
      exmem_src_chk: assert (exmem_we && (exmem_rd == src))
        else $error("execute/memory select without matching producer");
    end
  end
endmodule

// File: rtl/fwd_unit.sv
// Operand bypass selector for the two ALU inputs of the execute stage.
module fwd_unit #(
  parameter int REG_W  = 5,
  parameter int NUM_OP = 2
) (
  input  logic [4:0] rs_ex,
  input  logic [4:0] rt_ex,
  input  logic [4:0] exmem_rd,
  input  logic       exmem_we,
  input  logic [4:0] memwb_rd,
  input  logic       memwb_we,
  output logic [1:0] sel_a,
  output logic [1:0] sel_b
);
  localparam int OP_A = 0;
  localparam int OP_B = 1;

  logic [REG_W-1:0] src_vec [NUM_OP];
  logic [1:0]       sel_vec [NUM_OP];

  always_comb begin
    src_vec[OP_A] = rs_ex;
    src_vec[OP_B] = rt_ex;
  end

  // R5: one independent selector per operand
  for (genvar g = 0; g < NUM_OP; g++) begin : g_op
    fwd_operand_sel #(.REG_W(REG_W)) op_sel (
      .src      (src_vec[g]),
      .exmem_rd (exmem_rd),
      .exmem_we (exmem_we),
      .memwb_rd (memwb_rd),
      .memwb_we (memwb_we),
      .sel      (sel_vec[g])
    );
  end

  always_comb begin
    sel_a = sel_vec[OP_A];
    sel_b = sel_vec[OP_B];
  end

  // R7
  always_comb begin
    sel_a_code_chk: assert (sel_a != 2'b11)
      else $error("illegal select on operand A");
    sel_b_code_chk: assert (sel_b != 2'b11)
      else $error("illegal select on operand B");
  end
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  logic       clk;
  logic       rst_n;
  logic [4:0] rs_ex, rt_ex, exmem_rd, memwb_rd;
  logic       exmem_we, memwb_we;
  logic [1:0] sel_a, sel_b;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_unit dut_i (
    .rs_ex(rs_ex), .rt_ex(rt_ex),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we),
    .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample 1 ns later (combinational path)
  task automatic apply(input logic [4:0] s, t, er, input logic ew,
                       input logic [4:0] wr, input logic ww);
    @(negedge clk);
    rs_ex = s; rt_ex = t; exmem_rd = er; exmem_we = ew; memwb_rd = wr; memwb_we = ww;
    #1;
  endtask

  task automatic t_reset_idle();
    apply(5'd3, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R1 idle A", sel_a, 2'b00);
    chk("R1 idle B", sel_b, 2'b00);
  endtask

  task automatic t_exmem();
    apply(5'd7, 5'd9, 5'd7, 1'b1, 5'd1, 1'b1);
    chk("R2 exmem A", sel_a, 2'b10);
    chk("R5 B untouched", sel_b, 2'b00);
    apply(5'd2, 5'd12, 5'd12, 1'b1, 5'd30, 1'b1);
    chk("R2 exmem B", sel_b, 2'b10);
    chk("R5 A untouched", sel_a, 2'b00);
  endtask

  task automatic t_memwb();
    apply(5'd5, 5'd5, 5'd8, 1'b1, 5'd5, 1'b1);
    chk("R3 wb A", sel_a, 2'b01);
    chk("R3 wb B", sel_b, 2'b01);
  endtask

  task automatic t_double();
    apply(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1);
    chk("R4 double A", sel_a, 2'b10);
    chk("R4 double B", sel_b, 2'b10);
    apply(5'd1, 5'd6, 5'd1, 1'b0, 5'd1, 1'b1);
    chk("R4 young disabled A", sel_a, 2'b01);
  endtask

  task automatic t_split();
    apply(5'd10, 5'd11, 5'd11, 1'b1, 5'd10, 1'b1);
    chk("R5 split A", sel_a, 2'b01);
    chk("R5 split B", sel_b, 2'b10);
  endtask

  task automatic t_zero();
    apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R6 zero A", sel_a, 2'b00);
    chk("R6 zero B", sel_b, 2'b00);
    apply(5'd0, 5'd3, 5'd0, 1'b1, 5'd3, 1'b1);
    chk("R6 zero young, old hit B", sel_b, 2'b01);
    chk("R6 zero A only", sel_a, 2'b00);
  endtask

  task automatic t_disabled();
    apply(5'd14, 5'd14, 5'd14, 1'b0, 5'd14, 1'b0);
    chk("R8 disabled A", sel_a, 2'b00);
    chk("R8 disabled B", sel_b, 2'b00);
  endtask

  task automatic t_comb();
    // R9: change inputs and observe without any rising edge in between
    @(negedge clk);
    rs_ex = 5'd20; rt_ex = 5'd21; exmem_rd = 5'd20; exmem_we = 1'b1;
    memwb_rd = 5'd21; memwb_we = 1'b1;
    #0.5;
    chk("R9 immediate A", sel_a, 2'b10);
    memwb_we = 1'b0;
    #0.5;
    chk("R9 immediate B", sel_b, 2'b00);
  endtask

  function automatic logic [1:0] ref_sel(input logic [4:0] s, er, input logic ew,
                                         input logic [4:0] wr, input logic ww);
    logic young_ok, old_ok;
    young_ok = ew && er != 0 && er == s;
    old_ok   = ww && wr != 0 && wr == s;
    if (young_ok) return 2'b10;
    if (old_ok)   return 2'b01;
    return 2'b00;
  endfunction

  task automatic t_sweep();
    for (int s = 0; s < 4; s++)
      for (int er = 0; er < 4; er++)
        for (int wr = 0; wr < 4; wr++)
          for (int en = 0; en < 4; en++) begin
            apply(5'(s), 5'(3 - s), 5'(er), en[0], 5'(wr), en[1]);
            chk("R1 sweep A", sel_a, ref_sel(5'(s), 5'(er), en[0], 5'(wr), en[1]));
            chk("R5 sweep B", sel_b, ref_sel(5'(3 - s), 5'(er), en[0], 5'(wr), en[1]));
            checks++;
            if (sel_a == 2'b11 || sel_b == 2'b11) begin
              errors++;
              $display("FAIL R7 act=%b/%b exp=not 11", sel_a, sel_b);
            end
          end
  endtask

  initial begin
    rst_n = 1'b0;
    rs_ex = '0; rt_ex = '0; exmem_rd = '0; memwb_rd = '0;
    exmem_we = 1'b0; memwb_we = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_exmem();
    t_memwb();
    t_double();
    t_split();
    t_zero();
    t_disabled();
    t_comb();
    t_sweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule